// File: doc/BRIEF.md
# Receive Bit-Clock Divider Chain

This block turns a fast system clock into a receive serial bit clock. It does so with three dividers in series. The first is a fixed divide-by-eight stage that can be bypassed. The second is a prescaler with an 8-bit modulus. The last is a divide-by-two toggle, which makes the high and low phases equal in length. The block does not produce a second clock. It drives a bit-clock level, and it drives one-cycle enable pulses on the rising and falling bit-clock edges, so logic downstream stays in the system clock domain.

A second, independent divider produces a high-frequency tick and a matching level. Its ratio is set by a 4-bit field.

Configuration comes from input ports and is copied into an internal active copy. The chain adopts the new value only at a terminal count, so a change never shortens or stretches a phase that is already running. One combination of range bit and modulus is illegal. The block flags that combination and never adopts it.

Top module: `bclk_gen_top`

## Requirements
- R1: Synchronous reset drives `bclk`, `bclk_rise`, `bclk_fall`, `hf_tick`, `hf_clk` and `cfg_err` to 0. Reset also clears the active configuration to all zeros, whatever the inputs hold. After release, the first bit-clock rise therefore comes 8 cycles later, and `hf_tick` is high after the first clock edge.
- R2: With `cfg_range` = 0, the divide-by-eight stage is in series with the prescaler. The bit-clock period is 16 × (M+1) system clocks, where M is `cfg_modulus`.
- R3: With `cfg_range` = 1, the divide-by-eight stage is bypassed. The period is 2 × (M+1) system clocks. The prescaler ratio M+1 covers 1 to 256.
- R4: The shortest legal period is 4 system clocks (`cfg_range` = 1, M = 1). The longest is 4096 system clocks (`cfg_range` = 0, M = 255).
- R5: The low phase and the high phase each last exactly half the period.
- R6: The pair `cfg_range` = 1 with M = 0 is illegal. `cfg_err` is high in the cycle after the inputs show that pair and low in the cycle after they do not. An illegal pair is never adopted: the previous period continues.
- R7: A new modulus or range value takes effect only at the next bit-clock edge. The phase running when the inputs change keeps its old length.
- R8: `bclk_rise` is high for exactly the one cycle in which `bclk` first reads 1. `bclk_fall` is high for exactly the one cycle in which `bclk` first reads 0. Neither pulse occurs at any other time.
- R9: `hf_tick` pulses once every F+1 system clocks, where F is `cfg_hfdiv` (0 to 15). `hf_clk` toggles with each pulse. A new F is adopted at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_modulus | input | 8 | Prescaler modulus M (ratio M+1) |
| cfg_range | input | 1 | 1 = bypass the divide-by-eight stage |
| cfg_hfdiv | input | 4 | High-frequency divider field F (ratio F+1) |
| bclk | output | 1 | Bit-clock level |
| bclk_rise | output | 1 | One-cycle enable on the bit-clock rising edge |
| bclk_fall | output | 1 | One-cycle enable on the bit-clock falling edge |
| hf_tick | output | 1 | One-cycle high-frequency enable |
| hf_clk | output | 1 | High-frequency level, toggles on each tick |
| cfg_err | output | 1 | Illegal range/modulus pair presented |

## Verification
The chain is run through these configurations:
- The range bit at 0 and at 1 with the same small modulus values, which separates a missing or inverted divide-by-eight stage from a wrong prescaler count.
- The two extreme settings (shortest and longest period), which expose off-by-one counting and counter width errors.
- The illegal pair, which separates a design that merely flags it from one that also adopts it.
- A configuration change in the middle of a long phase, which tells deferred adoption apart from immediate adoption.
- Reset with non-zero inputs, which shows whether reset truly clears the active configuration.
- Three high-frequency field values, which check the tick interval and its level toggle.

// File: rtl/bclk_div_pkg.sv
package bclk_div_pkg;

    localparam int unsigned MOD_W   = 8;
    localparam int unsigned HF_W    = 4;
    localparam int unsigned FIX_DIV = 8;
    localparam int unsigned FIX_W   = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

    typedef logic [MOD_W-1:0] mod_t;
    typedef logic [HF_W-1:0]  hf_t;

    // Settings that shape the bit-clock chain
    typedef struct packed {
        logic bypass;   // 1: skip the fixed stage
        mod_t modv;     // prescaler modulus, ratio modv+1
    } chain_cfg_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_e;

    // Bypassed fixed stage with modulus zero gives a runt half period
    function automatic logic chain_cfg_illegal(chain_cfg_t c);
        return c.bypass && (c.modv == '0);
    endfunction

    function automatic edge_e next_edge(logic tc, logic lvl);
        edge_e e;
        if (!tc)
            e = EDGE_NONE;
        else if (lvl)
            e = EDGE_FALL;
        else
            e = EDGE_RISE;
        return e;
    endfunction

endpackage

// File: rtl/bclk_fixed_stage.sv
module bclk_fixed_stage
    import bclk_div_pkg::*;
#(
    parameter int unsigned DIV = FIX_DIV,
    parameter int unsigned W   = FIX_W
) (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    output logic tick
);

    logic [W-1:0] cnt;
    logic         at_end;

    generate
        if ((1 << W) == DIV) begin : g_pow2
            assign at_end = &cnt;
        end else begin : g_cmp
            assign at_end = (cnt == W'(DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || bypass)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = bypass | at_end;

endmodule

// File: rtl/bclk_mod_stage.sv
module bclk_mod_stage
    import bclk_div_pkg::*;
#(
    parameter int unsigned W = MOD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         tc
);

    logic [W-1:0] cnt;
    logic         wrap;

    assign wrap = (cnt == limit);
    assign tc   = tick & wrap;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/bclk_cfg_shadow.sv
module bclk_cfg_shadow
    import bclk_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chain_cfg_t req,
    input  logic       load,
    output chain_cfg_t act,
    output logic       err
);

    logic req_bad;

    assign req_bad = chain_cfg_illegal(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
            err <= 1'b0;
        end else begin
            err <= req_bad;
            if (load && !req_bad)
                act <= req;
        end
    end

endmodule

// File: rtl/bclk_hf_div.sv
module bclk_hf_div
    import bclk_div_pkg::*;
#(
    parameter int unsigned W = HF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req,
    output logic         tick,
    output logic         lvl
);

    logic [W-1:0] act;
    logic [W-1:0] cnt;
    logic         tc;

    assign tc = (cnt == act);

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= '0;
            cnt  <= '0;
            tick <= 1'b0;
            lvl  <= 1'b0;
        end else begin
            tick <= tc;
            if (tc) begin
                cnt <= '0;
                lvl <= ~lvl;
                act <= req;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bclk_gen_top.sv
module bclk_gen_top
    import bclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [MOD_W-1:0] cfg_modulus,
    input  logic             cfg_range,
    input  logic [HF_W-1:0]  cfg_hfdiv,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             hf_tick,
    output logic             hf_clk,
    output logic             cfg_err
);

    chain_cfg_t req_cfg;
    chain_cfg_t act_cfg;
    logic       fix_tick;
    logic       chain_tc;
    edge_e      ev;
    logic       bclk_q;
    logic       rise_q;
    logic       fall_q;

    assign req_cfg = '{bypass: cfg_range, modv: cfg_modulus};

    bclk_cfg_shadow i_shadow (
        .clk  (clk),
        .rst  (rst),
        .req  (req_cfg),
        .load (chain_tc),
        .act  (act_cfg),
        .err  (cfg_err)
    );

    bclk_fixed_stage #(.DIV(FIX_DIV), .W(FIX_W)) i_fixed (
        .clk    (clk),
        .rst    (rst),
        .bypass (act_cfg.bypass),
        .tick   (fix_tick)
    );

    bclk_mod_stage #(.W(MOD_W)) i_mod (
        .clk   (clk),
        .rst   (rst),
        .tick  (fix_tick),
        .limit (act_cfg.modv),
        .tc    (chain_tc)
    );

    // Final divide-by-two with edge enables aligned to the new level
    assign ev = next_edge(chain_tc, bclk_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= (ev == EDGE_RISE);
            fall_q <= (ev == EDGE_FALL);
            if (ev != EDGE_NONE)
                bclk_q <= ~bclk_q;
        end
    end

    assign bclk      = bclk_q;
    assign bclk_rise = rise_q;
    assign bclk_fall = fall_q;

    bclk_hf_div #(.W(HF_W)) i_hf (
        .clk  (clk),
        .rst  (rst),
        .req  (cfg_hfdiv),
        .tick (hf_tick),
        .lvl  (hf_clk)
    );

endmodule

// File: rtl/bclk_gen_chk.sv
module bclk_gen_chk
    import bclk_div_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [MOD_W-1:0] cfg_modulus,
    input logic             cfg_range,
    input logic             bclk,
    input logic             bclk_rise,
    input logic             bclk_fall,
    input logic             hf_tick,
    input logic             hf_clk,
    input logic             cfg_err
);

    // R8
    rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_rise |-> $rose(bclk));

    // R8
    fall_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_fall |-> $fell(bclk));

    // R8
    level_move_chk: assert property (@(posedge clk) disable iff (rst)
        (bclk != $past(bclk)) |-> (bclk_rise || bclk_fall));

    // R4
    min_half_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_rise |=> !bclk_fall);

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_range && cfg_modulus == '0) |=> cfg_err);

    // R6
    err_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_range && cfg_modulus == '0) |=> !cfg_err);

    // R9
    hf_move_chk: assert property (@(posedge clk) disable iff (rst)
        (hf_clk != $past(hf_clk)) |-> hf_tick);

    // R9
    hf_tick_chk: assert property (@(posedge clk) disable iff (rst)
        hf_tick |-> (hf_clk != $past(hf_clk)));

endmodule

bind bclk_gen_top bclk_gen_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_modulus (cfg_modulus),
    .cfg_range   (cfg_range),
    .bclk        (bclk),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .hf_tick     (hf_tick),
    .hf_clk      (hf_clk),
    .cfg_err     (cfg_err)
);

// File: tb/test_bclk_gen_top.sv
`timescale 1ns/1ps
module test_bclk_gen_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_modulus = '0;
    logic       cfg_range = 1'b0;
    logic [3:0] cfg_hfdiv = '0;
    logic       bclk, bclk_rise, bclk_fall, hf_tick, hf_clk, cfg_err;

    bclk_gen_top i_bclk_gen_top (
        .clk         (clk),
        .rst         (rst),
        .cfg_modulus (cfg_modulus),
        .cfg_range   (cfg_range),
        .cfg_hfdiv   (cfg_hfdiv),
        .bclk        (bclk),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .hf_tick     (hf_tick),
        .hf_clk      (hf_clk),
        .cfg_err     (cfg_err)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        int    per;
        string req;
    } exp_t;

    exp_t q[$];
    int   rise_cnt  = 0;
    int   last_rise = 0;
    int   last_fall = 0;
    int   edge_bad  = 0;
    logic prev_b    = 1'b0;

    // Monitor: pops expected periods and compares at each rise
    always @(negedge clk) begin
        if (rst) begin
            prev_b = bclk;
        end else begin
            if (bclk !== prev_b) begin
                if (bclk_rise !== bclk || bclk_fall !== !bclk) edge_bad++;
            end else if (bclk_rise || bclk_fall) begin
                edge_bad++;
            end
            prev_b = bclk;
            if (bclk_fall) last_fall = cyc;
            if (bclk_rise) begin
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check((cyc - last_rise) == e.per, e.req, "bit-clock period",
                          cyc - last_rise, e.per);
                    check((cyc - last_fall) == e.per / 2, "R5", "low phase length",
                          cyc - last_fall, e.per / 2);
                end
                last_rise = cyc;
                rise_cnt++;
            end
        end
    end

    // Driver: applies a setting, lets it settle, then queues expected periods
    task automatic run_cfg(input logic rng, input logic [7:0] m, input int per,
                           input int n, input string req);
        @(negedge clk);
        cfg_range   = rng;
        cfg_modulus = m;
        repeat (2) @(rise_cnt);
        for (int i = 0; i < n; i++) q.push_back('{per: per, req: req});
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic hf_measure(input logic [3:0] f);
        int   n;
        logic l0;
        @(negedge clk);
        cfg_hfdiv = f;
        repeat (40) @(negedge clk);
        while (!hf_tick) @(negedge clk);
        l0 = hf_clk;
        n  = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!hf_tick);
        check(n == int'(f) + 1, "R9", "hf tick interval", n, int'(f) + 1);
        check(hf_clk != l0, "R9", "hf level toggled", hf_clk, !l0);
    endtask

    function automatic int p16(input int m);
        return 16 * (m + 1);
    endfunction

    initial begin
        int n;
        cfg_range   = 1'b1;
        cfg_modulus = 8'd5;
        cfg_hfdiv   = 4'd5;
        repeat (4) @(negedge clk);
        check({bclk, bclk_rise, bclk_fall, hf_tick, hf_clk, cfg_err} == 6'b0,
              "R1", "outputs during reset",
              int'({bclk, bclk_rise, bclk_fall, hf_tick, hf_clk, cfg_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(hf_tick == 1'b1, "R1", "hf field cleared, tick after first edge", hf_tick, 1);
        repeat (6) @(negedge clk);
        check(bclk == 1'b0, "R1", "bclk still low after 7 edges", bclk, 0);
        @(negedge clk);
        // R7: first phase uses cleared config even though inputs differ
        check(bclk == 1'b1 && bclk_rise == 1'b1, "R1 R7", "first rise after 8 edges",
              int'({bclk, bclk_rise}), 3);

        run_cfg(1'b1, 8'd5, 12, 2, "R3");
        run_cfg(1'b0, 8'd0, p16(0), 2, "R2");
        run_cfg(1'b0, 8'd3, p16(3), 2, "R2");
        run_cfg(1'b1, 8'd6, 14, 2, "R3");
        run_cfg(1'b1, 8'd1, 4, 3, "R4");
        run_cfg(1'b1, 8'd255, 512, 2, "R3");

        @(negedge clk);
        cfg_range   = 1'b1;
        cfg_modulus = 8'd0;
        @(negedge clk);
        check(cfg_err == 1'b1, "R6", "illegal pair flagged", cfg_err, 1);
        run_cfg(1'b1, 8'd0, 512, 2, "R6");
        @(negedge clk);
        cfg_modulus = 8'd1;
        @(negedge clk);
        check(cfg_err == 1'b0, "R6", "flag cleared for legal pair", cfg_err, 0);

        run_cfg(1'b0, 8'd255, 4096, 2, "R4");

        @(rise_cnt);
        repeat (100) @(negedge clk);
        cfg_range   = 1'b1;
        cfg_modulus = 8'd1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bclk_fall);
        check(n == 1948, "R7", "running phase kept old length", n, 1948);
        run_cfg(1'b1, 8'd1, 4, 2, "R7");

        hf_measure(4'd0);
        hf_measure(4'd15);
        hf_measure(4'd7);

        check(edge_bad == 0 && rise_cnt > 0, "R8", "edge pulse mismatches", edge_bad, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule